// File: doc/BRIEF.md
# Fetch Address Sequencer with Return Stack

This block holds the instruction fetch address of a small single-accumulator processor. It also keeps a shallow hardware stack of return addresses. In every cycle the core's decoder reports what the instruction now executing asks for: a plain step, a subroutine call, a return or a conditional skip. The sequencer then picks the next fetch address. The address is 11 bits wide and wraps at 2048.

Calls, returns and skips all waste the word already fetched behind them. The sequencer raises a squash flag for the following cycle, and the core executes that word as a no-op. A call target is built from an 8-bit immediate for the low byte, a forced zero in bit 8, and two page bits taken from status bits 6:5. A call can therefore only reach the lower half of a 512-word page.

The return stack holds two entries. A push onto a full stack silently drops the oldest address, and no flag reports it.

Top module: `pcstk_top`

## Requirements
- R1: While rst_n is low and after its release, fetch_addr is 0x7FF and squash is 0, and both stack entries hold 0x000. A return issued before any call therefore jumps to 0x000.
- R2: With squash low and op 2'b00 with skip low, the next fetch_addr is the current one plus 1, modulo 2048 (0x7FF is followed by 0x000).
- R3: With squash low, op 2'b00 and skip high, the next fetch_addr is the current one plus 1, and squash is high in the next cycle.
- R4: With squash low and op 2'b01 (call), the next fetch_addr has bits 7:0 equal to imm, bit 8 equal to 0 and bits 10:9 equal to page, and squash is high in the next cycle.
- R5: A call pushes the fetch_addr of its own cycle, which is the call's address plus 1. A later return lands there.
- R6: With squash low and op 2'b10 (return), the next fetch_addr is the top stack entry, the stack is popped, and squash is high in the next cycle.
- R7: A push onto a stack that already holds two entries drops the oldest one. A pop copies the lower entry to the top and leaves the lower entry unchanged, so returning more often than calling repeats that address.
- R8: In a cycle with squash high, op, imm, page and skip have no effect. fetch_addr advances by 1, squash falls in the next cycle, and the stack is left unchanged.
- R9: Op code 2'b11 behaves exactly like op 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Decoded operation: 00 step, 01 call, 10 return, 11 treated as step |
| imm_i | input | 8 | Call target, low address byte |
| page_i | input | 2 | Status bits 6:5, upper address bits for a call |
| skip_i | input | 1 | Skip request from a bit test that succeeded |
| fetch_addr_o | output | 11 | Address of the word fetched this cycle |
| squash_o | output | 1 | The word now executing must be replaced by a no-op |

## Verification
The bench targets wrap-around from 0x7FF to 0x000. A design that saturates or reloads the vector there would stall the fetch stream. A call with page bits 11 and an immediate whose top bit is set checks that bit 8 is really cleared. A design that passes bit 8 through would jump to the upper half of the page.

Three calls followed by three returns cover overflow. The third return must repeat the second return's address; a design that empties the stack to zero would return to 0x000 instead. A call presented during a squash cycle must be ignored. A design that decodes it anyway would jump and corrupt the stack.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

  localparam int unsigned PC_ADDR_W = 11;
  localparam int unsigned PC_IMM_W  = 8;
  localparam int unsigned PC_PAGE_W = 2;
  localparam int unsigned PC_DEPTH  = 2;

  typedef enum logic [1:0] {
    OP_STEP = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_RSVD = 2'b11
  } pc_op_e;

  typedef enum logic [1:0] {
    SEL_INC  = 2'b00,
    SEL_CALL = 2'b01,
    SEL_RET  = 2'b10
  } pc_sel_e;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcstk_pkg::*;
(
  input  pc_op_e  op_i,
  input  logic    skip_i,
  input  logic    squash_i,
  output logic    push_o,
  output logic    pop_o,
  output logic    flush_o,
  output pc_sel_e sel_o
);

  always_comb begin
    push_o  = 1'b0;
    pop_o   = 1'b0;
    flush_o = 1'b0;
    sel_o   = SEL_INC;
    if (!squash_i) begin
      unique case (op_i)
        OP_CALL: begin
          push_o  = 1'b1;
          flush_o = 1'b1;
          sel_o   = SEL_CALL;
        end
        OP_RET: begin
          pop_o   = 1'b1;
          flush_o = 1'b1;
          sel_o   = SEL_RET;
        end
        default: begin
          flush_o = skip_i;
        end
      endcase
    end
  end

  // R8: a squashed slot never touches the stack
  always_comb begin
    if (squash_i) begin
      a_r8_no_stack_when_squashed: assert (!push_o && !pop_o);
    end
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [W-1:0] ent_q [DEPTH];
  logic [W-1:0] ent_d [DEPTH];
  logic         en;

  assign en = push_i | pop_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      ent_d[i] = ent_q[i];
      if (push_i) begin
        if (i == 0) ent_d[i] = data_i;
        else        ent_d[i] = ent_q[(i == 0) ? 0 : i - 1];
      end else if (pop_i) begin
        if (i == LAST) ent_d[i] = ent_q[i];
        else           ent_d[i] = ent_q[(i == LAST) ? LAST : i + 1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[i] <= '0;
      else if (en) ent_q[i] <= ent_d[i];
    end
  end

  assign top_o = ent_q[0];

  // R5: pushed address appears on top
  a_r5_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> (top_o == $past(data_i)));

  // R7: pop keeps the bottom entry in place
  a_r7_pop_keeps_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (ent_q[LAST] == $past(ent_q[LAST])));

  // R7: push shifts the previous top down
  a_r7_push_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (ent_q[LAST] == $past(ent_q[(LAST == 0) ? 0 : LAST - 1])
                            || (LAST == 0)));

endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcstk_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned PAGE_W = 2
) (
  input  pc_sel_e           sel_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] top_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam int unsigned GAP_W = ADDR_W - IMM_W - PAGE_W;

  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] pc_call;

  assign pc_inc  = pc_i + ADDR_W'(1);
  assign pc_call = {page_i, {GAP_W{1'b0}}, imm_i};

  always_comb begin
    unique case (sel_i)
      SEL_CALL: pc_o = pc_call;
      SEL_RET:  pc_o = top_i;
      default:  pc_o = pc_inc;
    endcase
  end

endmodule

// File: rtl/pcstk_top.sv
module pcstk_top
  import pcstk_pkg::*;
#(
  parameter int unsigned ADDR_W = PC_ADDR_W,
  parameter int unsigned IMM_W  = PC_IMM_W,
  parameter int unsigned PAGE_W = PC_PAGE_W,
  parameter int unsigned DEPTH  = PC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              skip_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              squash_o
);

  localparam logic [ADDR_W-1:0] RESET_VEC = '1;

  pc_op_e            op;
  pc_sel_e           sel;
  logic              push, pop, flush;
  logic [ADDR_W-1:0] top;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              sq_q, sq_d;
  logic              pc_en;

  assign op = pc_op_e'(op_i);

  pcs_decode u_dec (
    .op_i     (op),
    .skip_i   (skip_i),
    .squash_i (sq_q),
    .push_o   (push),
    .pop_o    (pop),
    .flush_o  (flush),
    .sel_o    (sel)
  );

  pcs_ret_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .pop_i  (pop),
    .data_i (pc_q),
    .top_o  (top)
  );

  pcs_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W)) u_tgt (
    .sel_i  (sel),
    .pc_i   (pc_q),
    .imm_i  (imm_i),
    .page_i (page_i),
    .top_i  (top),
    .pc_o   (pc_d)
  );

  always_comb begin
    pc_en = 1'b1;
    sq_d  = flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
      sq_q <= 1'b0;
    end else if (pc_en) begin
      pc_q <= pc_d;
      sq_q <= sq_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign squash_o     = sq_q;

  // R2 / R9: plain step advances by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_o && (op_i == 2'b00 || op_i == 2'b11) && !skip_i)
      |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)) && !squash_o);

  // R3: skip advances and squashes
  a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_o && op_i == 2'b00 && skip_i)
      |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)) && squash_o);

  // R4: call target layout
  a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_o && op_i == 2'b01)
      |=> (fetch_addr_o[IMM_W-1:0] == $past(imm_i))
       && (fetch_addr_o[ADDR_W-1 -: PAGE_W] == $past(page_i))
       && (fetch_addr_o[IMM_W] == 1'b0) && squash_o);

  // R6: return takes top of stack
  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!squash_o && op_i == 2'b10) |=> (fetch_addr_o == $past(top)) && squash_o);

  // R8: squashed slot only advances
  a_r8_squash_slot: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1)) && !squash_o);

endmodule

// File: tb/test_pcstk_top.sv
module test_pcstk_top;

  logic        clk;
  logic        rst_n;
  logic [1:0]  op_i;
  logic [7:0]  imm_i;
  logic [1:0]  page_i;
  logic        skip_i;
  logic [10:0] fetch_addr_o;
  logic        squash_o;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 0;

  logic [10:0] m_pc;
  logic        m_sq;
  logic [10:0] m_s0, m_s1;

  pcstk_top i_pcstk_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .imm_i        (imm_i),
    .page_i       (page_i),
    .skip_i       (skip_i),
    .fetch_addr_o (fetch_addr_o),
    .squash_o     (squash_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [10:0] exp_a, input logic exp_s);
    n_checks++;
    if (fetch_addr_o !== exp_a || squash_o !== exp_s) begin
      n_errors++;
      $display("FAIL %s: addr=%h squash=%b expected addr=%h squash=%b",
               tag, fetch_addr_o, squash_o, exp_a, exp_s);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] imm,
                      input logic [1:0] pg, input logic sk, input string tag);
    logic [10:0] npc;
    logic        nsq;
    string       t;
    op_i = op; imm_i = imm; page_i = pg; skip_i = sk;
    if (m_sq) begin
      npc = m_pc + 11'd1; nsq = 1'b0; t = "R8";
    end else begin
      case (op)
        2'b01: begin
          npc = {pg, 1'b0, imm}; m_s1 = m_s0; m_s0 = m_pc; nsq = 1'b1; t = "R4";
        end
        2'b10: begin
          npc = m_s0; m_s0 = m_s1; nsq = 1'b1; t = "R6";
        end
        default: begin
          npc = m_pc + 11'd1; nsq = sk;
          t = sk ? "R3" : ((op == 2'b11) ? "R9" : "R2");
        end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    m_pc = npc;
    m_sq = nsq;
    check((tag == "") ? t : tag, m_pc, m_sq);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20061));
    rst_n = 1'b0;
    op_i = 2'b00; imm_i = 8'h00; page_i = 2'b00; skip_i = 1'b0;
    m_pc = 11'h7FF; m_sq = 1'b0; m_s0 = 11'h000; m_s1 = 11'h000;
    repeat (3) @(negedge clk);
    check("R1", 11'h7FF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 11'h7FF, 1'b0);
    rst_n = 1'b1;

    step(2'b00, 8'h00, 2'b00, 1'b0, "R2");      // 0x7FF wraps to 0x000
    step(2'b10, 8'h00, 2'b00, 1'b0, "R1");      // return from empty stack
    step(2'b01, 8'hAA, 2'b11, 1'b1, "R8");      // ignored call in squash slot
    step(2'b00, 8'h00, 2'b00, 1'b1, "R3");
    step(2'b11, 8'h00, 2'b00, 1'b1, "R8");
    step(2'b11, 8'h33, 2'b01, 1'b0, "R9");
    step(2'b01, 8'hDA, 2'b11, 1'b0, "R4");      // target 0x6DA, bit 8 cleared
    step(2'b00, 8'h00, 2'b00, 1'b0, "R8");
    step(2'b01, 8'h10, 2'b01, 1'b0, "R5");
    step(2'b00, 8'h00, 2'b00, 1'b0, "R8");
    step(2'b01, 8'hFF, 2'b10, 1'b0, "R7");      // third call overflows
    step(2'b00, 8'h00, 2'b00, 1'b0, "R8");
    step(2'b10, 8'h00, 2'b00, 1'b0, "R5");
    step(2'b00, 8'h00, 2'b00, 1'b0, "R8");
    step(2'b10, 8'h00, 2'b00, 1'b0, "R6");
    step(2'b00, 8'h00, 2'b00, 1'b0, "R8");
    step(2'b10, 8'h00, 2'b00, 1'b0, "R7");      // repeats bottom entry
    step(2'b10, 8'h00, 2'b00, 1'b0, "R8");      // return ignored in squash slot

    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [1:0]  op;
      r = $urandom_range(0, 99);
      if (r < 55)      op = 2'b00;
      else if (r < 72) op = 2'b01;
      else if (r < 90) op = 2'b10;
      else             op = 2'b11;
      step(op, 8'($urandom), 2'($urandom), ($urandom_range(0, 4) == 0), "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule